// File: doc/BRIEF.md
# Latched Serial-In Parallel-Out Output Driver

This block is the logic core of a chainable display column driver. A serial bit stream is clocked into a shift chain, one stage per rising edge of a serial clock. A latch bank copies the chain while its load control is high and freezes while that control is low. A drive-enable input either passes the latched word to the parallel outputs or pulls every output low. The last stage of the chain is presented on a serial output, so several drivers can be connected in a daisy chain and loaded from one data line.

The whole block runs on a fast system clock. The serial clock is an ordinary data input whose rising edges are detected in that domain. The latch is modelled as a register that reloads on every system clock cycle while its load control is high. A build-time parameter chooses the forward or mirrored mapping from chain stage to output pin, so both board orientations come from one source.

Top module: `sipo_latch_driver`

## Requirements
- R1: A synchronous active-high reset clears every chain stage and every latch bit, so after reset `par_out` is all zero with `drv_en` high and `ser_dout` is 0.
- R2: On each system clock cycle where `ser_clk` is 1 and was 0 on the previous cycle, stage 0 takes `ser_din` and every stage k>0 takes the old value of stage k-1. The chain holds its contents while `ser_clk` stays high or stays low.
- R3: `ser_dout` always equals the last chain stage (stage WIDTH-1).
- R4: While `load_en` is high, the latch bank takes the chain contents on every system clock edge, so it matches the chain one cycle later.
- R5: While `load_en` is low, the latch bank keeps its value whatever the chain does.
- R6: While `drv_en` is 0, every bit of `par_out` is 0 in the same cycle, whatever the latch holds.
- R7: While `drv_en` is 1, `par_out` shows the latched word.
- R8: With DIR = forward, `par_out[i]` is latch bit i (stage i). With DIR = reverse, `par_out[i]` is latch bit WIDTH-1-i.
- R9: `load_en` and `drv_en` have no effect on shifting: the chain contents and `ser_dout` follow R2 whatever values they take.
- R10: In a chain of two drivers, with the second driver's `ser_din` fed from the first driver's `ser_dout`, the second driver holds the first WIDTH bits sent once 2*WIDTH bits have been shifted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Serial clock; its rising edge advances the chain |
| ser_din | input | 1 | Serial data into stage 0 |
| load_en | input | 1 | Latch load control, level sensitive |
| drv_en | input | 1 | Output drive enable; 0 forces all outputs low |
| par_out | output | WIDTH | Parallel outputs |
| ser_dout | output | 1 | Last chain stage, for cascading |

## Verification
A rising edge of `ser_clk` applied before a system clock edge shifts the chain at that edge, so `ser_dout` is due one cycle after the serial edge. While `load_en` is high, the latch and `par_out` follow one cycle after that. `drv_en` acts on `par_out` in the same cycle. Each serial bit is sent over two system cycles, with the clock high in the first and low in the second. Inputs change at the falling edge, and every check is made at the falling edge after the second cycle, when all registered results are settled. Checks on the enable are made a few nanoseconds after the enable changes. A reference model of the chain, the latch and the cascaded second device, kept in the bench, gives the expected values for random and directed sequences.

// File: rtl/sipo_pkg.sv
package sipo_pkg;
   typedef enum logic {
      DIR_FORWARD = 1'b0,
      DIR_REVERSE = 1'b1
   } dir_e;
endpackage

// File: rtl/sipo_shift_chain.sv
module sipo_shift_chain #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ser_clk,
   input  logic             ser_din,
   output logic [WIDTH-1:0] stages,
   output logic             ser_dout
);
   localparam int LAST = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("sipo_shift_chain: WIDTH must be at least 2");
   end

   logic             sclk_q;
   logic             rise;
   logic [WIDTH-1:0] sr;

   assign rise = ser_clk & ~sclk_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         sclk_q <= 1'b0;
         sr     <= '0;
      end else begin
         sclk_q <= ser_clk;
         if (rise) begin
            sr <= {sr[LAST-1:0], ser_din};
         end
      end
   end

   assign stages   = sr;
   assign ser_dout = sr[LAST];

   // R2: no serial edge, no movement
   a_r2_hold: assert property (@(posedge clk) disable iff (rst)
      !(ser_clk && !sclk_q) |=> $stable(sr));
   // R2: serial edge loads stage 0 from the data input
   a_r2_load: assert property (@(posedge clk) disable iff (rst)
      (ser_clk && !sclk_q) |=> sr[0] == $past(ser_din));
   // R2: serial edge moves every stage up by one
   a_r2_advance: assert property (@(posedge clk) disable iff (rst)
      (ser_clk && !sclk_q) |=> sr[LAST:1] == $past(sr[LAST-1:0]));
endmodule

// File: rtl/sipo_latch_bank.sv
module sipo_latch_bank #(
   parameter int WIDTH = 32
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             load_en,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (WIDTH < 1) begin : g_bad_width
      $error("sipo_latch_bank: WIDTH must be positive");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= '0;
      end else if (load_en) begin
         q <= d;
      end
   end

   // R4: transparent phase copies the chain
   a_r4_follow: assert property (@(posedge clk) disable iff (rst)
      load_en |=> q == $past(d));
   // R5: closed phase holds
   a_r5_hold: assert property (@(posedge clk) disable iff (rst)
      !load_en |=> $stable(q));
endmodule

// File: rtl/sipo_out_gate.sv
module sipo_out_gate
   import sipo_pkg::*;
#(
   parameter int   WIDTH = 32,
   parameter dir_e DIR   = DIR_FORWARD
) (
   input  logic [WIDTH-1:0] lat,
   input  logic             drv_en,
   output logic [WIDTH-1:0] pins
);
   localparam int LAST = WIDTH - 1;

   logic [WIDTH-1:0] mapped;

   for (genvar i = 0; i < WIDTH; i++) begin : g_map
      if (DIR == DIR_FORWARD) begin : g_fwd
         assign mapped[i] = lat[i];
      end else begin : g_rev
         assign mapped[i] = lat[LAST-i];
      end
   end

   assign pins = drv_en ? mapped : '0;
endmodule

// File: rtl/sipo_latch_driver.sv
module sipo_latch_driver
   import sipo_pkg::*;
#(
   parameter int   WIDTH = 32,
   parameter dir_e DIR   = DIR_FORWARD
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ser_clk,
   input  logic             ser_din,
   input  logic             load_en,
   input  logic             drv_en,
   output logic [WIDTH-1:0] par_out,
   output logic             ser_dout
);
   localparam int LAST = WIDTH - 1;

   if (WIDTH < 2 || WIDTH > 1024) begin : g_bad_width
      $error("sipo_latch_driver: WIDTH out of range 2..1024");
   end

   logic [WIDTH-1:0] chain;
   logic [WIDTH-1:0] held;

   sipo_shift_chain #(.WIDTH(WIDTH)) u_chain (
      .clk      (clk),
      .rst      (rst),
      .ser_clk  (ser_clk),
      .ser_din  (ser_din),
      .stages   (chain),
      .ser_dout (ser_dout)
   );

   sipo_latch_bank #(.WIDTH(WIDTH)) u_latch (
      .clk     (clk),
      .rst     (rst),
      .load_en (load_en),
      .d       (chain),
      .q       (held)
   );

   sipo_out_gate #(.WIDTH(WIDTH), .DIR(DIR)) u_gate (
      .lat    (held),
      .drv_en (drv_en),
      .pins   (par_out)
   );

   // R6: disabled outputs are all low
   a_r6_off_low: assert property (@(posedge clk) disable iff (rst)
      !drv_en |-> par_out == '0);
   // R7, R8: enabled outputs carry the latched bits, whatever the mapping
   a_r7_pass_count: assert property (@(posedge clk) disable iff (rst)
      drv_en |-> $countones(par_out) == $countones(held));
   // R3, R9: serial output tracks the last stage one serial edge after its source
   a_r3_dout_step: assert property (@(posedge clk) disable iff (rst)
      $changed(ser_dout) |-> $past(chain[LAST-1]) == ser_dout);
endmodule

// File: tb/test_sipo_latch_driver.sv
module test_sipo_latch_driver;
   import sipo_pkg::*;

   localparam int W = 32;

   logic clk = 1'b0;
   logic rst, sclk, din, le, oe;
   logic [W-1:0] po_f, po_r, po_b;
   logic dout_f, dout_r, dout_b;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [W-1:0] m_sr, m_lat, m_b;
   logic [W-1:0] first_bits;

   always #5 clk = ~clk;

   sipo_latch_driver #(.WIDTH(W), .DIR(DIR_FORWARD)) i_sipo_latch_driver (
      .clk(clk), .rst(rst), .ser_clk(sclk), .ser_din(din), .load_en(le),
      .drv_en(oe), .par_out(po_f), .ser_dout(dout_f));

   sipo_latch_driver #(.WIDTH(W), .DIR(DIR_REVERSE)) u_mirror (
      .clk(clk), .rst(rst), .ser_clk(sclk), .ser_din(din), .load_en(le),
      .drv_en(oe), .par_out(po_r), .ser_dout(dout_r));

   sipo_latch_driver #(.WIDTH(W), .DIR(DIR_FORWARD)) u_next (
      .clk(clk), .rst(rst), .ser_clk(sclk), .ser_din(dout_f), .load_en(1'b1),
      .drv_en(1'b1), .par_out(po_b), .ser_dout(dout_b));

   function automatic logic [W-1:0] flip(input logic [W-1:0] v);
      logic [W-1:0] r;
      for (int i = 0; i < W; i++) r[i] = v[W-1-i];
      return r;
   endfunction

   task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic check_all(input string req);
      chk({req, " fwd"}, po_f, oe ? m_lat : '0);
      chk({req, " R8 mirror"}, po_r, oe ? flip(m_lat) : '0);
      chk({req, " R3 dout"}, {{(W-1){1'b0}}, dout_f}, {{(W-1){1'b0}}, m_sr[W-1]});
      chk({req, " R10 next"}, po_b, m_b);
   endtask

   // one serial bit over two system cycles; load and drive held constant
   task automatic send(input logic b, input logic l, input logic o);
      @(negedge clk);
      din = b; sclk = 1'b1; le = l; oe = o;
      @(negedge clk);
      sclk = 1'b0;
      @(negedge clk);
      m_b  = {m_b[W-2:0], m_sr[W-1]};
      m_sr = {m_sr[W-2:0], b};
      if (l) m_lat = m_sr;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; sclk = 1'b0; din = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      m_sr = '0; m_lat = '0; m_b = '0;
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [W-1:0] snap;
      int unused;
      unused = $urandom(32'h5EED);
      rst = 1'b1; sclk = 1'b0; din = 1'b0; le = 1'b1; oe = 1'b1;
      do_reset();
      check_all("R1 reset");

      // directed: walking one, loaded transparently
      send(1'b1, 1'b1, 1'b1);
      check_all("R2 R4 R7 first bit");
      for (int k = 0; k < W - 1; k++) send(1'b0, 1'b1, 1'b1);
      check_all("R2 R3 bit at last stage");

      // R2: serial clock held high, then held low, data toggling
      @(negedge clk);
      sclk = 1'b1; din = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 6; k++) begin
         din = ~din;
         @(negedge clk);
      end
      sclk = 1'b0;
      m_b  = {m_b[W-2:0], m_sr[W-1]};
      m_sr = {m_sr[W-2:0], 1'b1};
      m_lat = m_sr;
      for (int k = 0; k < 6; k++) begin
         din = ~din;
         @(negedge clk);
      end
      check_all("R2 held clock one shift only");

      // R5 and R9: shift with load closed, outputs must not move
      snap = m_lat;
      for (int k = 0; k < 8; k++) send(1'(k % 3 == 0), 1'b0, 1'(k % 2));
      check_all("R5 R9 hold while shifting");
      chk("R5 latch unchanged", m_lat, snap);
      @(negedge clk);
      le = 1'b1; oe = 1'b1;
      @(negedge clk);
      m_lat = m_sr;
      check_all("R4 R9 open after closed shifts");

      // R6: disable drops outputs in the same cycle, re-enable restores
      @(negedge clk);
      oe = 1'b0;
      #2;
      chk("R6 disabled low", po_f, '0);
      chk("R6 disabled low mirror", po_r, '0);
      @(negedge clk);
      oe = 1'b1;
      #2;
      chk("R7 re-enabled", po_f, m_lat);

      // constrained random mix
      for (int k = 0; k < 120; k++) begin
         logic rb, rl, ro;
         rb = 1'($urandom);
         rl = ($urandom % 4) != 0;
         ro = ($urandom % 5) != 0;
         send(rb, rl, ro);
         check_all("R2 R4 R5 R6 R8 random");
      end

      // R10: cascade of two devices over 2*W shifts
      do_reset();
      first_bits = '0;
      for (int k = 0; k < 2 * W; k++) begin
         logic rb;
         rb = 1'($urandom);
         if (k < W) first_bits = {first_bits[W-2:0], rb};
         send(rb, 1'b1, 1'b1);
      end
      check_all("R10 cascade");
      chk("R10 second holds first word", po_b, first_bits);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule